// File: doc/BRIEF.md
# Dual-Bank Numerically Controlled Oscillator

This block is a master-clocked oscillator that builds a periodic waveform from a 28-bit phase accumulator. Software loads two frequency tuning words and two 12-bit phase offsets through a parallel write port. Two select pins then choose, cycle by cycle, which frequency word drives the accumulator and which offset is added to its top bits. Toggling the frequency select gives frequency-shift keying. Toggling the phase select gives phase-shift keying.

The adjusted phase feeds one of two outputs, chosen by a mode register. One is a 10-bit unsigned sine code, built from a quarter-wave table. The other is a linear ramp taken straight from the phase. A separate pin carries the phase MSB as a square wave. Every path from a select pin or a register write to the output has the same pipeline depth. A keyed switch therefore lands on a known clock edge.

Top module: `dualBankNco`

## Requirements
- R1: A clock edge with `rst` high clears the accumulator and all five registers, sets `waveOut` to 512 (mid-scale) and `signOut` to 0.
- R2: A write with `wrEn` high is applied at that clock edge, and `wrAddr` picks the target: 0 is frequency word A (all 28 bits of `wrData`), 1 is frequency word B, 2 is phase offset A (`wrData[11:0]`), 3 is phase offset B, and 4 is the mode register (`wrData[0]`, 1 = ramp, 0 = sine).
- R3: On each clock edge the accumulator adds, modulo 2^28, the frequency word chosen by `freqSel` (0 = A, 1 = B). A select change never resets the accumulated phase.
- R4: The adjusted phase is (accumulator bits [27:16] + the offset chosen by `phaseSel`) modulo 4096, where `phaseSel` 0 = A and 1 = B.
- R5: In ramp mode, `waveOut` equals bits [11:2] of the adjusted phase.
- R6: In sine mode, let i = phase[11:2], q = i[9:8] and a = i[7:0]. Let k = a when q[0] = 0, or 255 - a when q[0] = 1. Let m = floor(511*sin(pi*(k+0.5)/512) + 0.5). Then `waveOut` = 512 + m for q[1] = 0, or 511 - m for q[1] = 1.
- R7: `signOut` equals bit 11 of the adjusted phase in both modes.
- R8: A select-pin change or a register write sampled at clock edge n first shows at the outputs right after edge n+5. For the frequency path, the step between the outputs after edges n+4 and n+5 is the first one that uses the new word. Latency is the same for all of these sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select for the write |
| wrData | input | 28 | Write data |
| freqSel | input | 1 | Chooses frequency word A or B |
| phaseSel | input | 1 | Chooses phase offset A or B |
| waveOut | output | 10 | Sine or ramp code, unsigned |
| signOut | output | 1 | MSB of the adjusted phase |

## Verification
With the frequency words at zero the accumulator stays at zero, so every one of the 4096 phase offsets is swept in ramp mode and again in sine mode. These sweeps separate errors in the quarter folding, the table rounding and the sign bit. A single half-turn offset on bank B, brought in by the phase select, sets the exact edge of the select-to-output latency and shows that the unselected bank has no effect. Two frequency words chosen so the ramp steps by 1 and by 3 per cycle show continuous accumulation. They also show that a frequency switch changes the step size on exactly the specified edge, with no jump in phase.

// File: rtl/ncoPkg.sv
package ncoPkg;
  localparam int ACC_W = 28;
  localparam int PH_W = 12;
  localparam int OUT_W = 10;
  localparam int ADDR_W = 3;
  localparam int FREQ_BASE = 0;
  localparam int PHASE_BASE = 2;
  localparam int MODE_ADDR = 4;

  typedef struct packed {
    logic clear;
    logic rampMode;
    logic [PH_W-1:0] phaseWord;
    logic [ACC_W-1:0] freqWord;
  } ctrlStrobe_t;
endpackage

// File: rtl/ncoControl.sv
module ncoControl
  import ncoPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ACC_W-1:0]  wrData,
  input  logic              freqSel,
  input  logic              phaseSel,
  output ctrlStrobe_t       strobe
);
  localparam int BANKS = 2;

  logic [ACC_W-1:0] freqWords [BANKS];
  logic [PH_W-1:0]  phaseWords [BANKS];
  logic rampQ, fSelQ, pSelQ;

  for (genvar b = 0; b < BANKS; b++) begin : gBank
    logic [ACC_W-1:0] freqQ;
    logic [PH_W-1:0]  phaseQ;
    always_ff @(posedge clk) begin
      if (rst) begin
        freqQ  <= '0;
        phaseQ <= '0;
      end else if (wrEn) begin
        if (int'(wrAddr) == FREQ_BASE + b) freqQ <= wrData;
        if (int'(wrAddr) == PHASE_BASE + b) phaseQ <= wrData[PH_W-1:0];
      end
    end
    assign freqWords[b]  = freqQ;
    assign phaseWords[b] = phaseQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rampQ <= 1'b0;
      fSelQ <= 1'b0;
      pSelQ <= 1'b0;
    end else begin
      fSelQ <= freqSel;
      pSelQ <= phaseSel;
      if (wrEn && int'(wrAddr) == MODE_ADDR) rampQ <= wrData[0];
    end
  end

  always_comb begin
    strobe.clear     = rst;
    strobe.rampMode  = rampQ;
    strobe.freqWord  = freqWords[fSelQ];
    strobe.phaseWord = phaseWords[pSelQ];
  end
endmodule

// File: rtl/ncoDatapath.sv
module ncoDatapath
  import ncoPkg::*;
(
  input  logic             clk,
  input  ctrlStrobe_t      strobe,
  output logic [OUT_W-1:0] waveOut,
  output logic             signOut
);
  localparam int LUT_AW = OUT_W - 2;
  localparam int QN = 1 << LUT_AW;
  localparam int MID = 1 << (OUT_W - 1);
  localparam int AMP = MID - 1;
  localparam real PI = 3.14159265358979;

  function automatic logic [OUT_W-2:0] quarterSample(int k);
    real ang;
    ang = PI * (real'(k) + 0.5) / (2.0 * real'(QN));
    return (OUT_W-1)'($rtoi(real'(AMP) * $sin(ang) + 0.5));
  endfunction

  logic [OUT_W-2:0] quarterRom [QN];
  for (genvar k = 0; k < QN; k++) begin : gRom
    localparam logic [OUT_W-2:0] SAMPLE = quarterSample(k);
    assign quarterRom[k] = SAMPLE;
  end

  logic [ACC_W-1:0] acc;
  logic [PH_W-1:0]  phDly, phaseAdj;
  logic             modeDly, modeP, modeB, modeC;
  logic [OUT_W-1:0] rampB, rampC;
  logic             signB, signC;
  logic [OUT_W-2:0] lutVal;
  logic [LUT_AW-1:0] lutAddr;
  logic [OUT_W-1:0] folded;

  assign lutAddr = rampB[OUT_W-2] ? ~rampB[LUT_AW-1:0] : rampB[LUT_AW-1:0];
  assign folded = rampC[OUT_W-1] ? OUT_W'(MID - 1) - OUT_W'(lutVal)
                                 : OUT_W'(MID) + OUT_W'(lutVal);

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      acc      <= '0;
      phDly    <= '0;
      modeDly  <= 1'b0;
      phaseAdj <= '0;
      modeP    <= 1'b0;
      rampB    <= '0;
      signB    <= 1'b0;
      modeB    <= 1'b0;
      lutVal   <= '0;
      rampC    <= '0;
      signC    <= 1'b0;
      modeC    <= 1'b0;
      waveOut  <= OUT_W'(MID);
      signOut  <= 1'b0;
    end else begin
      acc      <= acc + strobe.freqWord;
      phDly    <= strobe.phaseWord;
      modeDly  <= strobe.rampMode;
      phaseAdj <= acc[ACC_W-1 -: PH_W] + phDly;
      modeP    <= modeDly;
      rampB    <= phaseAdj[PH_W-1 -: OUT_W];
      signB    <= phaseAdj[PH_W-1];
      modeB    <= modeP;
      lutVal   <= quarterRom[lutAddr];
      rampC    <= rampB;
      signC    <= signB;
      modeC    <= modeB;
      waveOut  <= modeC ? rampC : folded;
      signOut  <= signC;
    end
  end
endmodule

// File: rtl/dualBankNco.sv
module dualBankNco
  import ncoPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ACC_W-1:0]  wrData,
  input  logic              freqSel,
  input  logic              phaseSel,
  output logic [OUT_W-1:0]  waveOut,
  output logic              signOut
);
  ctrlStrobe_t ctrlBus;

  ncoControl control (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .freqSel(freqSel), .phaseSel(phaseSel), .strobe(ctrlBus)
  );

  ncoDatapath datapath (
    .clk(clk), .strobe(ctrlBus), .waveOut(waveOut), .signOut(signOut)
  );
endmodule

// File: rtl/dualBankNcoChecker.sv
module dualBankNcoChecker
  import ncoPkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ACC_W-1:0]  wrData,
  input logic              freqSel,
  input logic              phaseSel,
  input logic [OUT_W-1:0]  waveOut,
  input logic              signOut,
  input logic [ACC_W-1:0]  busFreq,
  input logic [PH_W-1:0]   busPhase,
  input logic              busRamp
);
  localparam int MID = 1 << (OUT_W - 1);
  logic [2:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  AST_RESET_MID: assert property (@(posedge clk)
    rst |=> (waveOut == OUT_W'(MID) && !signOut)); // R1

  AST_FREQ_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wrEn && int'(wrAddr) == FREQ_BASE && !freqSel) |=> busFreq == $past(wrData)); // R2

  AST_PHASE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wrEn && int'(wrAddr) == PHASE_BASE + 1 && phaseSel)
      |=> busPhase == $past(wrData[PH_W-1:0])); // R4

  AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'd2 && !wrEn && $stable(freqSel)) |=> $stable(busFreq)); // R3

  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'd6) |->
      (signOut == ($past(busRamp, 5) ? waveOut[OUT_W-1] : !waveOut[OUT_W-1]))); // R7
endmodule

bind dualBankNco dualBankNcoChecker checker_i (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .freqSel(freqSel), .phaseSel(phaseSel), .waveOut(waveOut), .signOut(signOut),
  .busFreq(ctrlBus.freqWord), .busPhase(ctrlBus.phaseWord), .busRamp(ctrlBus.rampMode)
);

// File: tb/dualBankNco_test.sv
module dualBankNco_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [27:0] wrData = '0;
  logic freqSel = 1'b0;
  logic phaseSel = 1'b0;
  logic [9:0] waveOut;
  logic signOut;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dualBankNco uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .freqSel(freqSel), .phaseSel(phaseSel), .waveOut(waveOut), .signOut(signOut)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeReg(int addr, int data);
    @(negedge clk);
    wrEn = 1'b1;
    wrAddr = 3'(addr);
    wrData = 28'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic int expSine(int p);
    int idx = p >> 2;
    int q = idx >> 8;
    int a = idx & 255;
    int k = (q & 1) ? 255 - a : a;
    int m = $rtoi(511.0 * $sin(3.14159265358979 * (real'(k) + 0.5) / 512.0) + 0.5);
    return (q & 2) ? 511 - m : 512 + m;
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    int prev;
    int cur;
    repeat (3) @(negedge clk);
    check("R1 reset wave", int'(waveOut), 512);
    check("R1 reset sign", int'(signOut), 0);
    rst = 1'b0;

    // R5 and R7: ramp sweep over every offset, accumulator held at zero
    writeReg(4, 1);
    for (int p = 0; p < 4096; p++) begin
      writeReg(2, p);
      repeat (5) @(negedge clk);
      check("R5 ramp", int'(waveOut), p >> 2);
      check("R7 sign ramp", int'(signOut), (p >> 11) & 1);
    end

    // R6 and R7: sine sweep over every offset
    writeReg(4, 0);
    for (int p = 0; p < 4096; p++) begin
      writeReg(2, p);
      repeat (5) @(negedge clk);
      check("R6 sine", int'(waveOut), expSine(p));
      check("R7 sign sine", int'(signOut), (p >> 11) & 1);
    end

    // R8: latency of the phase select, R4: unselected bank ignored
    writeReg(3, 12'h800);
    writeReg(2, 0);
    writeReg(4, 1);
    repeat (8) @(negedge clk);
    check("R4 bank B unselected", int'(waveOut), 0);
    phaseSel = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (i == 5) check("R8 before edge n+5", int'(waveOut), 0);
      if (i == 6) check("R8 at edge n+5", int'(waveOut), 512);
    end
    check("R2 phase bank B sign", int'(signOut), 1);
    phaseSel = 1'b0;

    // R3 and R8: frequency keying with steps of 1 and 3 per cycle
    writeReg(0, 1 << 18);
    writeReg(1, 3 << 18);
    repeat (8) @(negedge clk);
    prev = int'(waveOut);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      cur = int'(waveOut);
      check("R3 step word A", (cur - prev) & 1023, 1);
      prev = cur;
    end
    freqSel = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      cur = int'(waveOut);
      check("R8 frequency switch step", (cur - prev) & 1023, (i >= 6) ? 3 : 1);
      prev = cur;
    end

    // R1: reset in the middle of a run
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset wave", int'(waveOut), 512);
    check("R1 mid-run reset sign", int'(signOut), 0);
    finish();
  end
endmodule